// File: doc/BRIEF.md
# Dual Flag-Set Conditional Execution Unit

This unit performs the conditional part of a small scalar pipelined core. It holds two condition-flag sets, and software selects one of them on every instruction. Because there are two sets, a loop-counter comparison and a data comparison can both be live at the same time. A compare-subtract operation writes the difference to a destination register and refreshes the selected set. A conditional move picks one of its two operands from a test on a selected set. A conditional jump tests a set and sends a new fetch address after exactly one delay-slot instruction.

The unit takes one decoded micro-operation per cycle, qualified by `uop_valid`. It returns a registered register-file write one cycle later. It also returns a one-cycle redirect pulse with its target. The redirect is produced by a three-state sequencer:

- **ST_RUN**: no jump is pending.
  - A taken jump moves it to ST_SLOT.
- **ST_SLOT**: a taken jump is waiting for its delay-slot instruction.
  - The next valid micro-operation moves it to ST_EMIT.
  - Idle cycles keep it in ST_SLOT.
- **ST_EMIT**: the redirect pulse is driven.
  - A taken jump in this cycle moves it to ST_SLOT.
  - Anything else moves it to ST_RUN.

Top module: `dualcc_exec_unit`

## Requirements
- R1: Reset clears both flag sets to zero. While reset is held, `wr_en` and `redir_valid` stay low. Zero flags make equal and higher-or-same false, and make not-equal, greater-or-equal and lower true.
- R2: Kind 1 (compare-subtract) writes `src_a` minus the second operand to `dst_idx`. It loads the set named by `flag_sel` as follows:
  - N is bit 31 of the difference.
  - Z is set when the difference is zero.
  - C is set when there is no unsigned borrow (`src_a` >= operand).
  - V is signed overflow.
- R3: A compare-subtract to one set leaves the other set unchanged. Kinds 0, 2 and 3 leave both sets unchanged.
- R4: The 4-bit `cond` field is tested against the set named by `flag_sel`. The codes are:
  - 0: always
  - 1: equal (Z)
  - 2: not equal
  - 3: signed less (N != V)
  - 4: signed greater-or-equal
  - 5: unsigned lower (!C)
  - 6: unsigned higher-or-same (C)
  - 7: never
  - 8 to 15: also never.
- R5: Kind 2 (conditional move) writes `src_a` to `dst_idx` when the condition holds, and the second operand otherwise. It never stalls and never redirects.
- R6: The second operand is `src_b` when `use_imm` is 0. When `use_imm` is 1, it is `imm14` sign-extended to 32 bits.
- R7: An instruction in the cycle right after a compare-subtract sees the flags that compare-subtract produced.
- R8: A taken kind-3 jump arms a redirect.
  - The next valid micro-operation is the delay slot and executes normally.
  - In the cycle after that slot is accepted, `redir_valid` is high for exactly one cycle.
  - The target is the jump's `pc` plus `imm14` sign-extended and shifted left by 2.
  - Idle cycles before the slot delay the pulse.
- R9: A jump whose condition fails produces no redirect. No jump writes a register.
- R10: A jump placed in the delay slot is ignored and produces no redirect of its own. A jump in the redirect cycle is handled normally.
- R11: A register write appears one cycle after its micro-operation is accepted. A cycle with `uop_valid` low produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | Micro-operation present this cycle |
| uop_kind | input | 2 | 0 none, 1 compare-subtract, 2 conditional move, 3 conditional jump |
| flag_sel | input | 1 | Flag set written or tested |
| cond | input | 4 | Condition code |
| use_imm | input | 1 | Second operand from immediate |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second register operand |
| imm14 | input | 14 | Immediate or jump word offset |
| dst_idx | input | 5 | Destination register index |
| pc | input | 32 | Address of this micro-operation |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 32 | Register write data |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_target | output | 32 | Redirect address |

## Verification
The main sweep crosses eight operand values, chosen to include zero, one, all-ones and both signed extremes, against each other.

- Each pair is followed by a conditional move under every condition code.
- The signed and unsigned codes disagree on many of these pairs, so a swapped N/V or C use becomes visible.
- The same moves are also aimed at the set that was not written, which separates the two sets from each other.

Immediate operands at both 14-bit extremes test the sign extension.

The jump sequences cover four cases:

- a taken jump and an untaken jump;
- idle cycles before the delay slot;
- a jump inside the delay slot;
- a jump inside the redirect cycle.

Together these separate the timing of the pulse from the counting of the delay slot.

// File: rtl/dualcc_pkg.sv
package dualcc_pkg;
    localparam int XLEN     = 32;
    localparam int IMM_W    = 14;
    localparam int RIDX_W   = 5;
    localparam int CC_SETS  = 2;
    localparam int CC_SEL_W = (CC_SETS > 1) ? $clog2(CC_SETS) : 1;
    localparam int KIND_W   = 2;
    localparam int COND_W   = 4;
    localparam int CCF_W    = 4;
    localparam int WORD_SH  = 2;

    typedef enum logic [KIND_W-1:0] {
        K_NOP   = 2'd0,
        K_SUBCC = 2'd1,
        K_CMOV  = 2'd2,
        K_JCC   = 2'd3
    } uop_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } ccf_t;

    localparam logic [COND_W-1:0] C_ALWAYS = 4'd0;
    localparam logic [COND_W-1:0] C_EQ     = 4'd1;
    localparam logic [COND_W-1:0] C_NE     = 4'd2;
    localparam logic [COND_W-1:0] C_LT     = 4'd3;
    localparam logic [COND_W-1:0] C_GE     = 4'd4;
    localparam logic [COND_W-1:0] C_LO     = 4'd5;
    localparam logic [COND_W-1:0] C_HS     = 4'd6;
    localparam logic [COND_W-1:0] C_NEVER  = 4'd7;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SLOT = 2'd1,
        ST_EMIT = 2'd2
    } br_state_e;
endpackage

// File: rtl/dualcc_flag_bank.sv
module dualcc_flag_bank
    import dualcc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CC_SEL_W-1:0]     wr_sel,
    input  ccf_t                    wr_val,
    input  logic [CC_SEL_W-1:0]     rd_sel,
    output ccf_t                    rd_val,
    output logic [CC_SETS*CCF_W-1:0] all_flat
);
    genvar g;
    generate
        for (g = 0; g < CC_SETS; g++) begin : g_set
            ccf_t q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && (wr_sel == CC_SEL_W'(g))) begin
                    q <= wr_val;
                end
            end
            assign all_flat[g*CCF_W +: CCF_W] = q;
        end
    endgenerate

    assign rd_val = all_flat[rd_sel*CCF_W +: CCF_W];
endmodule

// File: rtl/dualcc_cond_eval.sv
module dualcc_cond_eval
    import dualcc_pkg::*;
(
    input  ccf_t              flags,
    input  logic [COND_W-1:0] cond,
    output logic              hold
);
    always_comb begin
        case (cond)
            C_ALWAYS: hold = 1'b1;
            C_EQ:     hold = flags.z;
            C_NE:     hold = !flags.z;
            C_LT:     hold = flags.n ^ flags.v;
            C_GE:     hold = !(flags.n ^ flags.v);
            C_LO:     hold = !flags.c;
            C_HS:     hold = flags.c;
            C_NEVER:  hold = 1'b0;
            default:  hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/dualcc_sub_flags.sv
module dualcc_sub_flags
    import dualcc_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] diff,
    output ccf_t            flags
);
    logic [XLEN:0] wide;

    always_comb begin
        wide    = {1'b0, opa} + {1'b0, ~opb} + {{XLEN{1'b0}}, 1'b1};
        diff    = wide[XLEN-1:0];
        flags.n = diff[XLEN-1];
        flags.z = (diff == '0);
        flags.c = wide[XLEN];
        flags.v = (opa[XLEN-1] != opb[XLEN-1]) && (diff[XLEN-1] != opa[XLEN-1]);
    end
endmodule

// File: rtl/dualcc_branch_fsm.sv
module dualcc_branch_fsm
    import dualcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uop_valid,
    input  logic             is_jcc,
    input  logic             cond_hold,
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] offset,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_target
);
    br_state_e       state, state_nxt;
    logic            take;
    logic [XLEN-1:0] tgt_calc;

    assign take     = uop_valid && is_jcc && cond_hold && (state != ST_SLOT);
    assign tgt_calc = pc + ({{(XLEN-IMM_W){offset[IMM_W-1]}}, offset} << WORD_SH);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:  if (take) state_nxt = ST_SLOT;
            ST_SLOT: if (uop_valid) state_nxt = ST_EMIT;
            ST_EMIT: state_nxt = take ? ST_SLOT : ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    redir_target <= '0;
        else if (take) redir_target <= tgt_calc;
    end

    always_comb begin
        redir_valid = (state == ST_EMIT);
    end
endmodule

// File: rtl/dualcc_exec_unit.sv
module dualcc_exec_unit
    import dualcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uop_valid,
    input  logic [1:0]        uop_kind,
    input  logic              flag_sel,
    input  logic [3:0]        cond,
    input  logic              use_imm,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    input  logic [13:0]       imm14,
    input  logic [4:0]        dst_idx,
    input  logic [31:0]       pc,
    output logic              wr_en,
    output logic [4:0]        wr_idx,
    output logic [31:0]       wr_data,
    output logic              redir_valid,
    output logic [31:0]       redir_target
);
    uop_kind_e                kind;
    logic [XLEN-1:0]          opnd_b;
    logic [XLEN-1:0]          diff;
    ccf_t                     new_flags;
    ccf_t                     sel_flags;
    logic                     cond_hold;
    logic                     is_sub;
    logic                     is_mov;
    logic [CC_SETS*CCF_W-1:0] cc_all;

    assign kind   = uop_kind_e'(uop_kind);
    assign is_sub = uop_valid && (kind == K_SUBCC);
    assign is_mov = uop_valid && (kind == K_CMOV);
    assign opnd_b = use_imm ? {{(XLEN-IMM_W){imm14[IMM_W-1]}}, imm14} : src_b;

    dualcc_sub_flags u_sub (
        .opa   (src_a),
        .opb   (opnd_b),
        .diff  (diff),
        .flags (new_flags)
    );

    dualcc_flag_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (is_sub),
        .wr_sel   (flag_sel),
        .wr_val   (new_flags),
        .rd_sel   (flag_sel),
        .rd_val   (sel_flags),
        .all_flat (cc_all)
    );

    dualcc_cond_eval u_cond (
        .flags (sel_flags),
        .cond  (cond),
        .hold  (cond_hold)
    );

    dualcc_branch_fsm u_br (
        .clk          (clk),
        .rst_n        (rst_n),
        .uop_valid    (uop_valid),
        .is_jcc       (kind == K_JCC),
        .cond_hold    (cond_hold),
        .pc           (pc),
        .offset       (imm14),
        .redir_valid  (redir_valid),
        .redir_target (redir_target)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en  <= is_sub || is_mov;
            wr_idx <= dst_idx;
            if (is_sub)      wr_data <= diff;
            else if (is_mov) wr_data <= cond_hold ? src_a : opnd_b;
        end
    end
endmodule

// File: rtl/dualcc_exec_chk.sv
module dualcc_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        uop_valid,
    input logic [1:0]  uop_kind,
    input logic [31:0] src_a,
    input logic [31:0] opnd_b,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        redir_valid,
    input logic [7:0]  cc_all
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!redir_valid && !wr_en && cc_all == 8'd0);
        end
    end

    // R11
    wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(uop_valid) && ($past(uop_kind) == 2'd1 || $past(uop_kind) == 2'd2)));

    // R9
    jcc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == 2'd3) |=> !wr_en);

    // R8
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R8
    redir_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> $past(uop_valid));

    // R3
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uop_valid && uop_kind == 2'd1) |=> $stable(cc_all));

    // R5
    cmov_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_kind == 2'd2) |=> (wr_en && (wr_data == $past(src_a) || wr_data == $past(opnd_b))));
endmodule

bind dualcc_exec_unit dualcc_exec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uop_valid   (uop_valid),
    .uop_kind    (uop_kind),
    .src_a       (src_a),
    .opnd_b      (opnd_b),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .redir_valid (redir_valid),
    .cc_all      (cc_all)
);

// File: tb/sim_dualcc_exec_unit.sv
module sim_dualcc_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        uop_valid;
    logic [1:0]  uop_kind;
    logic        flag_sel;
    logic [3:0]  cond;
    logic        use_imm;
    logic [31:0] src_a, src_b, pc;
    logic [13:0] imm14;
    logic [4:0]  dst_idx;
    logic        wr_en, redir_valid;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data, redir_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] la [2];
    logic [31:0] lb [2];
    bit          seen [2];

    always #10 clk = ~clk;

    dualcc_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_kind(uop_kind),
        .flag_sel(flag_sel), .cond(cond), .use_imm(use_imm), .src_a(src_a),
        .src_b(src_b), .imm14(imm14), .dst_idx(dst_idx), .pc(pc),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .redir_valid(redir_valid), .redir_target(redir_target)
    );

    function automatic logic [31:0] val(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h0000_0005;
            6: return 32'hFFFF_FFFB;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic bit exp_cond(input int c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            0: return 1'b1;
            1: return a == b;
            2: return a != b;
            3: return $signed(a) < $signed(b);
            4: return $signed(a) >= $signed(b);
            5: return a < b;
            6: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic s, input logic [3:0] c,
                         input logic ui, input logic [31:0] a, input logic [31:0] b,
                         input logic [13:0] im, input logic [4:0] d, input logic [31:0] p);
        uop_valid = 1'b1; uop_kind = k; flag_sel = s; cond = c; use_imm = ui;
        src_a = a; src_b = b; imm14 = im; dst_idx = d; pc = p;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        uop_valid = 1'b0; uop_kind = 2'd0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic mov_check(input string req, input logic s, input int c, input bit exp_hold);
        logic [31:0] ea;
        logic [31:0] eb;
        ea = 32'hAAAA_0000 + c;
        eb = 32'h5555_0000 + c;
        issue(2'd2, s, 4'(c), 1'b0, ea, eb, 14'd0, 5'd9, 32'd0);
        chk({req, " wr_en"}, {31'd0, wr_en}, 32'd1);
        chk(req, wr_data, exp_hold ? ea : eb);
    endtask

    initial begin
        for (int n = 0; n < 100000; n++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; uop_valid = 1'b0; uop_kind = '0; flag_sel = '0; cond = '0;
        use_imm = '0; src_a = '0; src_b = '0; imm14 = '0; dst_idx = '0; pc = '0;
        repeat (3) @(negedge clk);
        chk("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
        chk("R1 redir in reset", {31'd0, redir_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero flags on both sets
        for (int s = 0; s < 2; s++) begin
            mov_check("R1 zero eq", s[0], 1, 1'b0);
            mov_check("R1 zero ne", s[0], 2, 1'b1);
            mov_check("R1 zero ge", s[0], 4, 1'b1);
            mov_check("R1 zero lo", s[0], 5, 1'b1);
            mov_check("R1 zero hs", s[0], 6, 1'b0);
        end
        seen[0] = 1'b0; seen[1] = 1'b0;

        // R2 R4 R5 R7 R3: operand sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic s;
                logic [31:0] a;
                logic [31:0] b;
                s = 1'((i + j) & 1);
                a = val(i);
                b = val(j);
                issue(2'd1, s, 4'd0, 1'b0, a, b, 14'd0, 5'(i + j), 32'd0);
                chk("R2 subcc wr_en", {31'd0, wr_en}, 32'd1);
                chk("R2 subcc diff", wr_data, a - b);
                chk("R2 subcc idx", {27'd0, wr_idx}, 32'(i + j));
                la[s] = a; lb[s] = b; seen[s] = 1'b1;
                for (int c = 0; c < 10; c++)
                    mov_check("R4 R5 R7 cmov cond", s, c, exp_cond(c, a, b));
                if (seen[~s]) begin
                    mov_check("R3 other set lt", ~s, 3, exp_cond(3, la[~s], lb[~s]));
                    mov_check("R3 other set lo", ~s, 5, exp_cond(5, la[~s], lb[~s]));
                    mov_check("R3 other set eq", ~s, 1, exp_cond(1, la[~s], lb[~s]));
                end
            end
        end

        // R6 immediates
        issue(2'd1, 1'b0, 4'd0, 1'b1, 32'd5, 32'hDEAD_BEEF, 14'h3FFF, 5'd1, 32'd0);
        chk("R6 imm -1", wr_data, 32'd6);
        mov_check("R6 R4 lt after imm", 1'b0, 3, 1'b0);
        mov_check("R6 R4 lo after imm", 1'b0, 5, 1'b1);
        issue(2'd1, 1'b0, 4'd0, 1'b1, 32'd5, 32'd0, 14'h2000, 5'd1, 32'd0);
        chk("R6 imm min", wr_data, 32'd8197);
        issue(2'd1, 1'b0, 4'd0, 1'b1, 32'd5, 32'd0, 14'h1FFF, 5'd1, 32'd0);
        chk("R6 imm max", wr_data, 32'd5 - 32'd8191);
        issue(2'd2, 1'b0, 4'd7, 1'b1, 32'd1, 32'd2, 14'h2ABC, 5'd3, 32'd0);
        chk("R6 cmov imm", wr_data, 32'hFFFF_EABC);

        // R3: non-flag instructions keep flags
        issue(2'd1, 1'b0, 4'd0, 1'b0, 32'd3, 32'd3, 14'd0, 5'd1, 32'd0);
        idle();
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd9, 32'd1, 14'd0, 5'd1, 32'd0);
        chk("R11 nop no write", {31'd0, wr_en}, 32'd0);
        issue(2'd3, 1'b0, 4'd7, 1'b0, 32'd9, 32'd1, 14'd0, 5'd1, 32'h40);
        chk("R9 jcc no write", {31'd0, wr_en}, 32'd0);
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd1, 32'h44);
        chk("R9 untaken no redirect", {31'd0, redir_valid}, 32'd0);
        mov_check("R3 flags kept eq", 1'b0, 1, 1'b1);

        // R8: taken jump via flags of set 1
        issue(2'd1, 1'b1, 4'd0, 1'b0, 32'd1, 32'd2, 14'd0, 5'd2, 32'd0);
        issue(2'd3, 1'b1, 4'd3, 1'b0, 32'd0, 32'd0, 14'd5, 5'd0, 32'h1000);
        chk("R8 no pulse at jump", {31'd0, redir_valid}, 32'd0);
        mov_check("R8 slot executes", 1'b1, 0, 1'b1);
        chk("R8 pulse", {31'd0, redir_valid}, 32'd1);
        chk("R8 target", redir_target, 32'h1014);
        idle();
        chk("R8 pulse one cycle", {31'd0, redir_valid}, 32'd0);

        // R9: untaken jump
        issue(2'd3, 1'b1, 4'd4, 1'b0, 32'd0, 32'd0, 14'd5, 5'd0, 32'h2000);
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd0, 32'h2004);
        chk("R9 untaken", {31'd0, redir_valid}, 32'd0);

        // R8: idle before slot, negative offset
        issue(2'd3, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'h3FFE, 5'd0, 32'h100);
        idle();
        chk("R8 waits for slot", {31'd0, redir_valid}, 32'd0);
        chk("R11 idle no write", {31'd0, wr_en}, 32'd0);
        idle();
        chk("R8 still waiting", {31'd0, redir_valid}, 32'd0);
        mov_check("R8 late slot", 1'b0, 7, 1'b0);
        chk("R8 late pulse", {31'd0, redir_valid}, 32'd1);
        chk("R8 negative offset", redir_target, 32'h0F8);

        // R10: jump in the delay slot ignored
        issue(2'd3, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd1, 5'd0, 32'h200);
        issue(2'd3, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd1, 5'd0, 32'h300);
        chk("R10 first pulse", {31'd0, redir_valid}, 32'd1);
        chk("R10 first target", redir_target, 32'h204);
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd0, 32'h0);
        chk("R10 slot jump ignored", {31'd0, redir_valid}, 32'd0);
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd0, 32'h0);
        chk("R10 still no pulse", {31'd0, redir_valid}, 32'd0);

        // R10: jump in the redirect cycle is honoured
        issue(2'd3, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd2, 5'd0, 32'h500);
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd0, 32'h504);
        chk("R10 pulse a", redir_target, 32'h508);
        issue(2'd3, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd0, 32'h400);
        chk("R10 no pulse at second jump", {31'd0, redir_valid}, 32'd0);
        issue(2'd0, 1'b0, 4'd0, 1'b0, 32'd0, 32'd0, 14'd0, 5'd0, 32'h404);
        chk("R10 second pulse", {31'd0, redir_valid}, 32'd1);
        chk("R10 second target", redir_target, 32'h400);
        idle();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule